// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block holds a configurable number of machine-check reporting banks and records hardware error reports in them. Each bank has four 64-bit registers, and the block also keeps a capability word, a global control word and a global status word. An error source presents one injection request per cycle. A request carries a bank number, a bank status word, a global status word, an address, a miscellaneous word and an unconditional flag.

The logger first validates the request. It then applies one policy to uncorrected errors and a different one to corrected errors. An uncorrected error that is logged raises a one-cycle machine-check interrupt. An uncorrected error that arrives while a previous one is still being handled, or while machine-check handling is switched off, becomes a one-cycle fatal reset request instead. A request that is refused or dropped raises a one-cycle reject pulse with a reason code.

A plain write port lets the surrounding logic set control words and clear global status. A combinational read port exposes every register.

Top module: `mcb_logger`

## Requirements
- R1: Register map on the read and write ports. Bank b register k is at address 4*b+k, with k=0 control, k=1 status, k=2 address and k=3 misc. The globals follow the last bank at G=4*NUM_BANKS: G is capability, G+1 is global control and G+2 is global status. A read of any other address returns zero. Reads are combinational.
- R2: Capability bits 7:0 hold NUM_BANKS and bit 8 is set when a global control word exists. After reset, every bank control word and the global control word are all ones, and every status, address, misc and global status word is zero.
- R3: A request whose bank number is at or above NUM_BANKS is rejected with code 0. Otherwise, a request whose status lacks the valid bit (bit 63) is rejected with code 1. A rejected request changes no register.
- R4: A valid request whose status lacks action-required (bit 55) is dropped with code 3 while global status bit 2 (in-progress) is set, unless the unconditional flag is set. This check comes before every check on uncorrected errors.
- R5: An uncorrected request (status bit 61) is refused with code 2 in two cases: the global control word exists and is not all ones, or the target bank's control word is not all ones. Nothing is logged.
- R6: An uncorrected request that passes R5 while the in-progress bit is set or while mce_en is low pulses reset_req and logs nothing.
- R7: An uncorrected request that is otherwise accepted writes the bank's address, misc and status. The status gets overflow (bit 62) ORed in if the bank already held a valid entry. The request also copies its global status word into global status and pulses mce_irq.
- R8: A corrected request overwrites status, address and misc when the bank is empty or holds a corrected entry, and ORs in overflow if the bank held a valid entry. If the bank holds an uncorrected entry, only its overflow bit is set.
- R9: Every result (mce_irq, reset_req, rej_valid with rej_code, and the register updates) appears in the cycle after the clock edge that accepts the request. At most one of the three pulses is high at a time.
- R10: A write with wr_en high and req_valid low updates the addressed register. Writes to the capability word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Injection request present this cycle |
| req_bank | input | 8 | Target bank number |
| req_status | input | DATA_W | Bank status word of the request |
| req_gstatus | input | DATA_W | Global status word of the request |
| req_addr | input | DATA_W | Error address |
| req_misc | input | DATA_W | Miscellaneous error data |
| req_uncond | input | 1 | Log even when in-progress is set |
| mce_en | input | 1 | Machine-check handling enabled |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Register read data |
| mce_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | Fatal reset request pulse |
| rej_valid | output | 1 | Request refused or dropped |
| rej_code | output | 2 | 0 bad bank, 1 invalid status, 2 reporting off, 3 ignored |

## Verification
Each request is decided at the clock edge that sees it. The three pulses and the bank and global register updates are therefore all due exactly one cycle later. The bench applies a request on a falling edge and lets one rising edge pass. It then samples the pulses and reads back the touched bank on the next falling edge, before any further stimulus. A second sample one cycle later confirms that the pulse has dropped.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
   localparam int ST_VAL  = 63;
   localparam int ST_OVER = 62;
   localparam int ST_UC   = 61;
   localparam int ST_AR   = 55;
   localparam int GS_MCIP = 2;
   localparam int CAP_CTLP = 8;

   typedef enum logic [1:0] {
      REJ_BANK  = 2'd0,
      REJ_INVAL = 2'd1,
      REJ_OFF   = 2'd2,
      REJ_IGN   = 2'd3
   } rej_e;

   typedef enum logic [2:0] {
      ACT_NONE   = 3'd0,
      ACT_REJ    = 3'd1,
      ACT_FATAL  = 3'd2,
      ACT_LOG_UC = 3'd3,
      ACT_LOG_CE = 3'd4,
      ACT_OVF    = 3'd5
   } act_e;
endpackage

// File: rtl/mcb_decide.sv
module mcb_decide
   import mcb_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int DATA_W    = 64,
   parameter bit GCTL_EN   = 1'b1
) (
   input  logic [7:0]        req_bank,
   input  logic [DATA_W-1:0] req_status,
   input  logic              req_uncond,
   input  logic              mce_en,
   input  logic [DATA_W-1:0] bank_ctl,
   input  logic              bank_val,
   input  logic              bank_uc,
   input  logic [DATA_W-1:0] gctl,
   input  logic              in_progress,
   output act_e              act,
   output rej_e              rej,
   output logic [DATA_W-1:0] new_status
);
   localparam logic [7:0] BANK_LIMIT = 8'(NUM_BANKS);

   always_comb begin
      act        = ACT_NONE;
      rej        = REJ_BANK;
      new_status = req_status;
      if (req_bank >= BANK_LIMIT) begin
         act = ACT_REJ;
         rej = REJ_BANK;
      end else if (!req_status[ST_VAL]) begin
         act = ACT_REJ;
         rej = REJ_INVAL;
      end else if (!req_uncond && !req_status[ST_AR] && in_progress) begin
         act = ACT_REJ;
         rej = REJ_IGN;
      end else if (req_status[ST_UC]) begin
         if ((GCTL_EN && (gctl != '1)) || (bank_ctl != '1)) begin
            act = ACT_REJ;
            rej = REJ_OFF;
         end else if (in_progress || !mce_en) begin
            act = ACT_FATAL;
         end else begin
            act = ACT_LOG_UC;
            new_status[ST_OVER] = req_status[ST_OVER] | bank_val;
         end
      end else if (!bank_val || !bank_uc) begin
         act = ACT_LOG_CE;
         new_status[ST_OVER] = req_status[ST_OVER] | bank_val;
      end else begin
         act = ACT_OVF;
      end
   end
endmodule

// File: rtl/mcb_bank.sv
module mcb_bank
   import mcb_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_k,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              log_en,
   input  logic              ovf_en,
   input  logic [DATA_W-1:0] log_status,
   input  logic [DATA_W-1:0] log_addr,
   input  logic [DATA_W-1:0] log_misc,
   output logic [DATA_W-1:0] ctl_q,
   output logic [DATA_W-1:0] status_q,
   output logic [DATA_W-1:0] addr_q,
   output logic [DATA_W-1:0] misc_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q    <= '1;
         status_q <= '0;
         addr_q   <= '0;
         misc_q   <= '0;
      end else if (log_en) begin
         status_q <= log_status;
         addr_q   <= log_addr;
         misc_q   <= log_misc;
      end else if (ovf_en) begin
         status_q[ST_OVER] <= 1'b1;
      end else if (wr_en) begin
         case (wr_k)
            2'd0:    ctl_q    <= wr_data;
            2'd1:    status_q <= wr_data;
            2'd2:    addr_q   <= wr_data;
            default: misc_q   <= wr_data;
         endcase
      end
   end

   // R8: overflow-only update keeps the held entry
   a_r8_ovf_keeps_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_en |=> status_q[ST_OVER] && $stable(addr_q) && $stable(misc_q));

   // R2: control word comes out of reset as all ones
   a_r2_ctl_init: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ctl_q == '1));
endmodule

// File: rtl/mcb_logger.sv
module mcb_logger
   import mcb_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int DATA_W    = 64,
   parameter int ADDR_W    = 8,
   parameter bit GCTL_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [7:0]        req_bank,
   input  logic [DATA_W-1:0] req_status,
   input  logic [DATA_W-1:0] req_gstatus,
   input  logic [DATA_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_misc,
   input  logic              req_uncond,
   input  logic              mce_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              mce_irq,
   output logic              reset_req,
   output logic              rej_valid,
   output logic [1:0]        rej_code
);
   localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int GBASE = 4 * NUM_BANKS;
   localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(GBASE);
   localparam logic [ADDR_W-1:0] A_GCTL = ADDR_W'(GBASE + 1);
   localparam logic [ADDR_W-1:0] A_GST  = ADDR_W'(GBASE + 2);
   localparam logic [DATA_W-1:0] CAP_VALUE =
      DATA_W'(NUM_BANKS) | (DATA_W'(GCTL_EN) << CAP_CTLP);

   if (NUM_BANKS < 1 || NUM_BANKS > 255) begin : g_chk_banks
      $error("NUM_BANKS must be 1..255");
   end
   if (DATA_W < 64) begin : g_chk_width
      $error("DATA_W must be at least 64");
   end
   if (GBASE + 3 > (1 << ADDR_W)) begin : g_chk_addr
      $error("ADDR_W too small for the register map");
   end

   logic [DATA_W-1:0] b_ctl [NUM_BANKS];
   logic [DATA_W-1:0] b_st  [NUM_BANKS];
   logic [DATA_W-1:0] b_ad  [NUM_BANKS];
   logic [DATA_W-1:0] b_mi  [NUM_BANKS];
   logic [DATA_W-1:0] gctl_q, gstat_q;
   logic [SEL_W-1:0]  sel;
   logic [DATA_W-1:0] sel_ctl, sel_st, new_status;
   act_e              act;
   rej_e              rej;
   logic              wr_go;

   assign wr_go = wr_en && !req_valid;

   always_comb begin
      sel = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (req_bank == 8'(b)) sel = SEL_W'(b);
      end
      sel_ctl = b_ctl[sel];
      sel_st  = b_st[sel];
   end

   mcb_decide #(
      .NUM_BANKS(NUM_BANKS),
      .DATA_W   (DATA_W),
      .GCTL_EN  (GCTL_EN)
   ) u_decide (
      .req_bank   (req_bank),
      .req_status (req_status),
      .req_uncond (req_uncond),
      .mce_en     (mce_en),
      .bank_ctl   (sel_ctl),
      .bank_val   (sel_st[ST_VAL]),
      .bank_uc    (sel_st[ST_UC]),
      .gctl       (gctl_q),
      .in_progress(gstat_q[GS_MCIP]),
      .act        (act),
      .rej        (rej),
      .new_status (new_status)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit, bw;
      assign hit = req_valid && (req_bank == 8'(b));
      assign bw  = wr_go && (wr_addr < A_CAP) &&
                   (wr_addr[ADDR_W-1:2] == (ADDR_W-2)'(b));
      mcb_bank #(.DATA_W(DATA_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (bw),
         .wr_k      (wr_addr[1:0]),
         .wr_data   (wr_data),
         .log_en    (hit && (act == ACT_LOG_UC || act == ACT_LOG_CE)),
         .ovf_en    (hit && (act == ACT_OVF)),
         .log_status(new_status),
         .log_addr  (req_addr),
         .log_misc  (req_misc),
         .ctl_q     (b_ctl[b]),
         .status_q  (b_st[b]),
         .addr_q    (b_ad[b]),
         .misc_q    (b_mi[b])
      );
   end

   if (GCTL_EN) begin : g_gctl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           gctl_q <= '1;
         else if (wr_go && wr_addr == A_GCTL)  gctl_q <= wr_data;
      end
   end else begin : g_no_gctl
      assign gctl_q = '1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gstat_q   <= '0;
         mce_irq   <= 1'b0;
         reset_req <= 1'b0;
         rej_valid <= 1'b0;
         rej_code  <= 2'd0;
      end else begin
         if (req_valid && act == ACT_LOG_UC)   gstat_q <= req_gstatus;
         else if (wr_go && wr_addr == A_GST)   gstat_q <= wr_data;
         mce_irq   <= req_valid && (act == ACT_LOG_UC);
         reset_req <= req_valid && (act == ACT_FATAL);
         rej_valid <= req_valid && (act == ACT_REJ);
         rej_code  <= rej;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (rd_addr < A_CAP && rd_addr[ADDR_W-1:2] == (ADDR_W-2)'(b)) begin
            case (rd_addr[1:0])
               2'd0:    rd_data = b_ctl[b];
               2'd1:    rd_data = b_st[b];
               2'd2:    rd_data = b_ad[b];
               default: rd_data = b_mi[b];
            endcase
         end
      end
      if (rd_addr == A_CAP)  rd_data = CAP_VALUE;
      if (rd_addr == A_GCTL) rd_data = gctl_q;
      if (rd_addr == A_GST)  rd_data = gstat_q;
   end

   a_r3_bad_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_bank >= 8'(NUM_BANKS)) |=> (rej_valid && rej_code == 2'd0));

   a_r3_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_bank < 8'(NUM_BANKS) && !req_status[ST_VAL])
      |=> (rej_valid && rej_code == 2'd1));

   a_r4_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_bank < 8'(NUM_BANKS) && req_status[ST_VAL] && !req_uncond &&
       !req_status[ST_AR] && gstat_q[GS_MCIP]) |=> (rej_valid && rej_code == 2'd3));

   a_r6_fatal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && act == ACT_FATAL) |=> (reset_req && !mce_irq && $stable(gstat_q)));

   a_r7_irq_gstat: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && act == ACT_LOG_UC) |=> (mce_irq && gstat_q == $past(req_gstatus)));

   a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mce_irq, reset_req, rej_valid}));
endmodule

// File: tb/mcb_logger_tb.sv
module mcb_logger_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] V  = 64'h8000_0000_0000_0000;
   localparam logic [63:0] O  = 64'h4000_0000_0000_0000;
   localparam logic [63:0] U  = 64'h2000_0000_0000_0000;
   localparam logic [63:0] AR = 64'h0080_0000_0000_0000;
   localparam logic [63:0] ONES = '1;

   typedef struct packed {
      logic [7:0]  bank;
      logic [63:0] st;
      logic [63:0] gs;
      logic        unc;
      logic [1:0]  chk;
      logic        e_irq;
      logic        e_rst;
      logic        e_rej;
      logic [1:0]  e_code;
      logic [63:0] e_st;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t TBL [NV] = '{
      '{8'd5, V|64'h11, 64'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 64'd0},        // R3 far bank
      '{8'd4, V|64'h11, 64'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 64'd0},        // R3 edge bank
      '{8'd1, 64'h22,   64'd0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 2'd1, 64'd0},        // R3 no valid
      '{8'd0, V|64'h1,  64'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, V|64'h1},      // R8 empty
      '{8'd0, V|64'h2,  64'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, V|O|64'h2},    // R8 over CE
      '{8'd1, V|U|AR|64'h10, 64'h5, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, V|U|AR|64'h10}, // R7
      '{8'd2, V|64'h3,  64'd0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 2'd3, 64'd0},        // R4 drop
      '{8'd2, V|64'h3,  64'd0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, V|64'h3},      // R4 uncond
      '{8'd1, V|64'h4,  64'd0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, V|U|AR|O|64'h10}, // R8 UC held
      '{8'd3, V|U|AR|64'h7, 64'd0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 2'd0, 64'd0},    // R6 in progress
      '{8'd3, V|U|64'h8, 64'd0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 2'd3, 64'd0}        // R4 before UC
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_uncond = 1'b0, mce_en = 1'b1, wr_en = 1'b0;
   logic [7:0]  req_bank = '0, wr_addr = '0, rd_addr = '0;
   logic [63:0] req_status = '0, req_gstatus = '0, req_addr = '0, req_misc = '0, wr_data = '0;
   logic [63:0] rd_data;
   logic mce_irq, reset_req, rej_valid;
   logic [1:0] rej_code;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcb_logger dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
      .req_status(req_status), .req_gstatus(req_gstatus), .req_addr(req_addr),
      .req_misc(req_misc), .req_uncond(req_uncond), .mce_en(mce_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .mce_irq(mce_irq), .reset_req(reset_req),
      .rej_valid(rej_valid), .rej_code(rej_code)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [63:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic req(input logic [7:0] b, input logic [63:0] st, input logic [63:0] gs,
                      input logic unc, input logic [63:0] ad, input logic [63:0] mi);
      req_bank = b; req_status = st; req_gstatus = gs; req_uncond = unc;
      req_addr = ad; req_misc = mi; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [63:0] d);
      wr_addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic string tag_of(input int i);
      case (i)
         0, 1, 2: return "R3";
         5:       return "R7";
         6, 10:   return "R4";
         9:       return "R6";
         default: return "R8";
      endcase
   endfunction

   initial begin
      logic [63:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state and capability, R1 map
      rd(8'd16, d); chk("R2 capability", d, 64'h104);
      rd(8'd17, d); chk("R2 gctl init", d, ONES);
      rd(8'd18, d); chk("R2 gstat init", d, 64'd0);
      for (int b = 0; b < 4; b++) begin
         rd(8'(4*b), d);   chk("R2 bank ctl init", d, ONES);
         rd(8'(4*b+1), d); chk("R1 bank status init", d, 64'd0);
      end
      rd(8'd19, d); chk("R1 unmapped read", d, 64'd0);

      for (int i = 0; i < NV; i++) begin
         req(TBL[i].bank, TBL[i].st, TBL[i].gs, TBL[i].unc, 64'hA000 + 64'(i), 64'hC000 + 64'(i));
         chk({"R9 pulses ", tag_of(i)}, {61'd0, mce_irq, reset_req, rej_valid},
             {61'd0, TBL[i].e_irq, TBL[i].e_rst, TBL[i].e_rej});
         if (TBL[i].e_rej) chk({"R9 code ", tag_of(i)}, {62'd0, rej_code}, {62'd0, TBL[i].e_code});
         rd(8'(4*TBL[i].chk + 1), d);
         chk({"bank status ", tag_of(i)}, d, TBL[i].e_st);
      end

      // R10 clear global status through the write port
      wr(8'd18, 64'd0);
      rd(8'd18, d); chk("R10 gstat write", d, 64'd0);

      // R6 machine-check disabled
      mce_en = 1'b0;
      req(8'd3, V|U|AR|64'h9, 64'h5, 1'b0, 64'h1, 64'h2);
      chk("R6 reset_req when disabled", {63'd0, reset_req}, 64'd1);
      rd(8'd13, d); chk("R6 no logging", d, 64'd0);
      mce_en = 1'b1;

      // R5 bank control off
      wr(8'd8, 64'd0);
      req(8'd2, V|U|AR|64'h9, 64'h5, 1'b0, 64'h1, 64'h2);
      chk("R5 bank ctl off reject", {61'd0, rej_valid, rej_code}, {61'd0, 1'b1, 2'd2});
      rd(8'd9, d); chk("R5 bank untouched", d, V|64'h3);
      wr(8'd8, ONES);
      // R5 global control off
      wr(8'd17, 64'hFF);
      req(8'd2, V|U|AR|64'h9, 64'h5, 1'b0, 64'h1, 64'h2);
      chk("R5 gctl off reject", {61'd0, rej_valid, rej_code}, {61'd0, 1'b1, 2'd2});
      rd(8'd18, d); chk("R5 gstat untouched", d, 64'd0);
      wr(8'd17, ONES);

      // R7 uncorrected logged over a held corrected entry
      req(8'd0, V|U|AR|64'h44, 64'h5, 1'b0, 64'hBEEF, 64'h1234);
      chk("R7 irq", {63'd0, mce_irq}, 64'd1);
      rd(8'd1, d); chk("R7 status with overflow", d, V|U|AR|O|64'h44);
      rd(8'd2, d); chk("R7 R1 address word", d, 64'hBEEF);
      rd(8'd3, d); chk("R7 R1 misc word", d, 64'h1234);
      rd(8'd18, d); chk("R7 gstat copy", d, 64'h5);
      @(negedge clk);
      chk("R9 irq single cycle", {63'd0, mce_irq}, 64'd0);

      // R10 capability write ignored
      wr(8'd16, 64'd0);
      rd(8'd16, d); chk("R10 capability read-only", d, 64'h104);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule